// File: doc/BRIEF.md
# Multicore Private Region Decoder

This block sits in front of the private peripheral window of a small multicore cluster. It accepts one access per cycle on a plain register bus and decodes its address within an 8 KB window. It then does one of three things. Accesses to the snoop-control register set are served from a few local registers. Accesses to the interrupt CPU interfaces, the per-core timers and watchdogs, and the interrupt distributor are forwarded to those sub-blocks as one-cycle strobes. Unmapped addresses are reported with an error pulse.

The first interface slot and the first timer slot are aliases. Each resolves to the slot of the core making the request, and that core is named by the `core_id` input. Every timer slot holds its watchdog 0x20 bytes above the timer. The read data of the selected sub-block is sampled in the strobe cycle and returned in the next cycle, together with `ready`. Every access therefore completes exactly two cycles after it is presented, whatever its target.

Top module: `mpriv_decoder`

## Requirements
- R1: Each cycle with `req` high is one access. Its `ready` is high for exactly one cycle, two rising edges after the edge that sampled `req`. Requests may be issued on consecutive cycles.
- R2: The control word at offset 0x000 stores bit 0 of a write and reads it back in bit 0, with all other bits zero. It is zero after `rst`.
- R3: Offset 0x004 reads a configuration word. Bits 4 to 4+NCORES-1 are set, bits 1:0 hold NCORES-1, and every other bit is zero. This is 0xF3 for four cores.
- R4: Offsets 0x008 and 0x00C read zero. A write to 0x00C, or to any other snoop-control offset except 0x000, leaves the control word unchanged. Every undecoded snoop-control offset reads zero.
- R5: Addresses 0x100–0x1FF raise `cif_stb[core_id]`, with `sub_offs` equal to address bits 7:0.
- R6: Addresses 0x200+i*0x100 through 0x2FF+i*0x100, for i below NCORES, raise `cif_stb[i]`, with `sub_offs` equal to address bits 7:0.
- R7: Within a timer slot, offsets 0x00–0x1F raise the timer strobe, with `sub_offs` equal to address bits 4:0. The slot at 0x600 belongs to `core_id`, and the slot at 0x700+i*0x100 belongs to core i.
- R8: Offsets 0x20–0x3F of the same slots raise the matching `wdg_stb` bit, with `sub_offs` equal to address bits 4:0.
- R9: Addresses with bit 12 set (0x1000–0x1FFF) raise `dist_stb`, with `sub_offs` equal to address bits 11:0.
- R10: A strobe is high for one cycle, the cycle after the sampling edge. At most one strobe is high at a time. `sub_we` and `sub_wdata` carry the access during that cycle. A read returns the selected sub-block's read data from that cycle on `rdata`, together with `ready`.
- R11: An access to an unmapped address raises no strobe and completes normally, with `err` high alongside `ready` and `rdata` zero. Unmapped addresses are: interface or timer slots at or beyond NCORES, timer-slot offsets 0x40–0xFF, 0xB00–0xFFF when there are four cores, and an alias slot when `core_id` is not below NCORES.
- R12: A write completion returns `rdata` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, one access per cycle |
| we | input | 1 | Access is a write |
| addr | input | 13 | Byte offset inside the window |
| wdata | input | DW | Write data |
| core_id | input | 2 | Index of the requesting core |
| rdata | output | DW | Read data, valid with ready |
| ready | output | 1 | Access completion pulse |
| err | output | 1 | Unmapped-address pulse, with ready |
| cif_stb | output | NCORES | Interrupt CPU-interface strobe, one per core |
| tmr_stb | output | NCORES | Timer strobe, one per core |
| wdg_stb | output | NCORES | Watchdog strobe, one per core |
| dist_stb | output | 1 | Interrupt distributor strobe |
| sub_we | output | 1 | Write flag for the strobed sub-block |
| sub_offs | output | 12 | Offset inside the strobed sub-block |
| sub_wdata | output | DW | Write data for the strobed sub-block |
| cif_rdata | input | NCORES*DW | CPU-interface read data, core i at bits i*DW |
| tmr_rdata | input | NCORES*DW | Timer read data, core i at bits i*DW |
| wdg_rdata | input | NCORES*DW | Watchdog read data, core i at bits i*DW |
| dist_rdata | input | DW | Distributor read data |

## Verification
The properties assume that sub-blocks drive their read data combinationally during the strobe cycle. They also assume that `core_id` names an existing core whenever an alias slot is addressed, and that inputs are never unknown while `req` is high. The stimulus models every sub-block as a function of `sub_offs` with a distinct pattern for each core. It changes inputs only on falling edges and uses a `core_id` below four, so every alias and per-core slot is reached without leaving the assumed input space.

// File: rtl/mpriv_pkg.sv
package mpriv_pkg;
  localparam int WIN_BYTES = 8192;
  localparam int AW        = $clog2(WIN_BYTES);
  localparam int CIDW      = 2;
  localparam int OFFW      = 12;
  localparam int MAX_CORES = 4;

  // slot numbers (address bits 11:8) with behavioural meaning
  localparam int SLOT_SCU   = 0;
  localparam int SLOT_CIF_A = 1;
  localparam int SLOT_CIF_0 = 2;
  localparam int SLOT_TMR_A = 6;
  localparam int SLOT_TMR_0 = 7;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_SCU,
    TGT_CIF,
    TGT_TMR,
    TGT_WDG,
    TGT_DIST
  } tgt_e;

  typedef struct packed {
    tgt_e            tgt;
    logic [CIDW-1:0] core;
    logic [OFFW-1:0] offs;
  } route_t;
endpackage

// File: rtl/mpriv_addr_decode.sv
module mpriv_addr_decode
  import mpriv_pkg::*;
#(
  parameter int NCORES = 4
) (
  input  logic [AW-1:0]   addr,
  input  logic [CIDW-1:0] core_id,
  output route_t          route
);
  int slot;
  int idx;
  logic cid_ok;

  assign cid_ok = int'(core_id) < NCORES;

  always_comb begin
    route = '{tgt: TGT_NONE, core: '0, offs: '0};
    slot  = int'(addr[11:8]);
    idx   = 0;
    if (addr[12]) begin
      route.tgt  = TGT_DIST;
      route.offs = addr[OFFW-1:0];
    end else if (slot == SLOT_SCU) begin
      route.tgt  = TGT_SCU;
      route.offs = {4'h0, addr[7:0]};
    end else if (slot == SLOT_CIF_A) begin
      if (cid_ok) begin
        route.tgt  = TGT_CIF;
        route.core = core_id;
        route.offs = {4'h0, addr[7:0]};
      end
    end else if (slot >= SLOT_CIF_0 && slot < SLOT_CIF_0 + NCORES) begin
      route.tgt  = TGT_CIF;
      route.core = CIDW'(slot - SLOT_CIF_0);
      route.offs = {4'h0, addr[7:0]};
    end else if ((slot == SLOT_TMR_A && cid_ok) ||
                 (slot >= SLOT_TMR_0 && slot < SLOT_TMR_0 + NCORES)) begin
      idx = (slot == SLOT_TMR_A) ? int'(core_id) : slot - SLOT_TMR_0;
      if (addr[7:6] == 2'b00) begin
        route.tgt  = addr[5] ? TGT_WDG : TGT_TMR;
        route.core = CIDW'(idx);
        route.offs = {7'h00, addr[4:0]};
      end
    end
  end
endmodule

// File: rtl/mpriv_scu_regs.sv
module mpriv_scu_regs
  import mpriv_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int DW     = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc,
  input  logic          wr,
  input  logic [7:0]    offs,
  input  logic          wr_bit,
  output logic [DW-1:0] rd
);
  localparam logic [DW-1:0] CFG_WORD =
    DW'((((1 << NCORES) - 1) << 4) | (NCORES - 1));

  logic ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= 1'b0;
    else if (acc && wr && offs == 8'h00) ctrl_q <= wr_bit;
  end

  always_comb begin
    case (offs)
      8'h00:   rd = {{(DW-1){1'b0}}, ctrl_q};
      8'h04:   rd = CFG_WORD;
      default: rd = '0;
    endcase
  end
endmodule

// File: rtl/mpriv_rd_mux.sv
module mpriv_rd_mux
  import mpriv_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int DW     = 32
) (
  input  route_t                 route,
  input  logic [DW-1:0]          scu_rd,
  input  logic [NCORES*DW-1:0]   cif_rd,
  input  logic [NCORES*DW-1:0]   tmr_rd,
  input  logic [NCORES*DW-1:0]   wdg_rd,
  input  logic [DW-1:0]          dist_rd,
  output logic [DW-1:0]          rd
);
  int sel;
  assign sel = (int'(route.core) < NCORES) ? int'(route.core) : 0;

  always_comb begin
    case (route.tgt)
      TGT_SCU:  rd = scu_rd;
      TGT_CIF:  rd = cif_rd[sel*DW +: DW];
      TGT_TMR:  rd = tmr_rd[sel*DW +: DW];
      TGT_WDG:  rd = wdg_rd[sel*DW +: DW];
      TGT_DIST: rd = dist_rd;
      default:  rd = '0;
    endcase
  end
endmodule

// File: rtl/mpriv_decoder.sv
module mpriv_decoder
  import mpriv_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int DW     = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req,
  input  logic                 we,
  input  logic [12:0]          addr,
  input  logic [DW-1:0]        wdata,
  input  logic [1:0]           core_id,
  output logic [DW-1:0]        rdata,
  output logic                 ready,
  output logic                 err,
  output logic [NCORES-1:0]    cif_stb,
  output logic [NCORES-1:0]    tmr_stb,
  output logic [NCORES-1:0]    wdg_stb,
  output logic                 dist_stb,
  output logic                 sub_we,
  output logic [11:0]          sub_offs,
  output logic [DW-1:0]        sub_wdata,
  input  logic [NCORES*DW-1:0] cif_rdata,
  input  logic [NCORES*DW-1:0] tmr_rdata,
  input  logic [NCORES*DW-1:0] wdg_rdata,
  input  logic [DW-1:0]        dist_rdata
);
  route_t              dec;
  route_t              s1_route;
  logic                s1_vld;
  logic [DW-1:0]       scu_rd;
  logic [DW-1:0]       mux_rd;
  logic [NCORES-1:0]   cif_nxt;
  logic [NCORES-1:0]   tmr_nxt;
  logic [NCORES-1:0]   wdg_nxt;

  mpriv_addr_decode #(.NCORES(NCORES)) u_dec (
    .addr    (addr),
    .core_id (core_id),
    .route   (dec)
  );

  // per-core strobe enables
  for (genvar i = 0; i < NCORES; i++) begin : g_core
    assign cif_nxt[i] = req && dec.tgt == TGT_CIF && dec.core == CIDW'(i);
    assign tmr_nxt[i] = req && dec.tgt == TGT_TMR && dec.core == CIDW'(i);
    assign wdg_nxt[i] = req && dec.tgt == TGT_WDG && dec.core == CIDW'(i);
  end

  // stage 1: decoded access and strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld    <= 1'b0;
      s1_route  <= '{tgt: TGT_NONE, core: '0, offs: '0};
      cif_stb   <= '0;
      tmr_stb   <= '0;
      wdg_stb   <= '0;
      dist_stb  <= 1'b0;
      sub_we    <= 1'b0;
      sub_offs  <= '0;
      sub_wdata <= '0;
    end else begin
      s1_vld    <= req;
      s1_route  <= req ? dec : '{tgt: TGT_NONE, core: '0, offs: '0};
      cif_stb   <= cif_nxt;
      tmr_stb   <= tmr_nxt;
      wdg_stb   <= wdg_nxt;
      dist_stb  <= req && dec.tgt == TGT_DIST;
      sub_we    <= req && we;
      sub_offs  <= req ? dec.offs : '0;
      sub_wdata <= req ? wdata : '0;
    end
  end

  mpriv_scu_regs #(.NCORES(NCORES), .DW(DW)) u_scu (
    .clk    (clk),
    .rst    (rst),
    .acc    (s1_vld && s1_route.tgt == TGT_SCU),
    .wr     (sub_we),
    .offs   (s1_route.offs[7:0]),
    .wr_bit (sub_wdata[0]),
    .rd     (scu_rd)
  );

  mpriv_rd_mux #(.NCORES(NCORES), .DW(DW)) u_mux (
    .route   (s1_route),
    .scu_rd  (scu_rd),
    .cif_rd  (cif_rdata),
    .tmr_rd  (tmr_rdata),
    .wdg_rd  (wdg_rdata),
    .dist_rd (dist_rdata),
    .rd      (mux_rd)
  );

  // stage 2: completion
  always_ff @(posedge clk) begin
    if (rst) begin
      ready <= 1'b0;
      err   <= 1'b0;
      rdata <= '0;
    end else begin
      ready <= s1_vld;
      err   <= s1_vld && s1_route.tgt == TGT_NONE;
      rdata <= (s1_vld && !sub_we) ? mux_rd : '0;
    end
  end
endmodule

// File: rtl/mpriv_decoder_chk.sv
module mpriv_decoder_chk #(
  parameter int NCORES = 4,
  parameter int DW     = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic              we,
  input logic [12:0]       addr,
  input logic [DW-1:0]     rdata,
  input logic              ready,
  input logic              err,
  input logic [NCORES-1:0] cif_stb,
  input logic [NCORES-1:0] tmr_stb,
  input logic [NCORES-1:0] wdg_stb,
  input logic              dist_stb
);
  localparam logic [DW-1:0] CFG_EXP =
    DW'((((1 << NCORES) - 1) << 4) | (NCORES - 1));

  logic [3*NCORES:0] all_stb;
  assign all_stb = {dist_stb, wdg_stb, tmr_stb, cif_stb};

  a_r1_ready_two_after: assert property (@(posedge clk) disable iff (rst)
    req |=> ##1 ready);

  a_r1_ready_has_req: assert property (@(posedge clk) disable iff (rst)
    ready |-> $past(req, 2));

  a_r10_single_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0(all_stb));

  a_r10_strobe_after_req: assert property (@(posedge clk) disable iff (rst)
    (|all_stb) |-> $past(req));

  a_r11_err_with_ready: assert property (@(posedge clk) disable iff (rst)
    err |-> (ready && rdata == '0));

  a_r11_hole_no_strobe: assert property (@(posedge clk) disable iff (rst)
    (req && addr[12] == 1'b0 && addr[11:8] == 4'hF) |=> (all_stb == '0));

  a_r3_config_word: assert property (@(posedge clk) disable iff (rst)
    (req && !we && addr == 13'h004) |=> ##1 (rdata == CFG_EXP));

  a_r2_ctrl_one_bit: assert property (@(posedge clk) disable iff (rst)
    (req && !we && addr == 13'h000) |=> ##1 (rdata[DW-1:1] == '0));

  a_r12_write_zero: assert property (@(posedge clk) disable iff (rst)
    (req && we) |=> ##1 (rdata == '0));
endmodule

bind mpriv_decoder mpriv_decoder_chk #(.NCORES(NCORES), .DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req      (req),
  .we       (we),
  .addr     (addr),
  .rdata    (rdata),
  .ready    (ready),
  .err      (err),
  .cif_stb  (cif_stb),
  .tmr_stb  (tmr_stb),
  .wdg_stb  (wdg_stb),
  .dist_stb (dist_stb)
);

// File: tb/sim_mpriv_decoder.sv
`timescale 1ns/1ps
module sim_mpriv_decoder;
  localparam int N  = 4;
  localparam int DW = 32;

  typedef struct {
    logic [3*N:0]  stb;
    logic [11:0]   offs;
    logic          we;
    logic [DW-1:0] wd;
    string         tag;
  } stb_item_t;

  typedef struct {
    logic [DW-1:0] rd;
    logic          er;
    string         tag;
  } rsp_item_t;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req = 1'b0;
  logic            we  = 1'b0;
  logic [12:0]     addr = '0;
  logic [DW-1:0]   wdata = '0;
  logic [1:0]      core_id = '0;
  logic [DW-1:0]   rdata;
  logic            ready, err, dist_stb, sub_we;
  logic [N-1:0]    cif_stb, tmr_stb, wdg_stb;
  logic [11:0]     sub_offs;
  logic [DW-1:0]   sub_wdata;
  logic [N*DW-1:0] cif_rdata, tmr_rdata, wdg_rdata;
  logic [DW-1:0]   dist_rdata;

  int total = 0;
  int bad   = 0;
  logic ctrl_m = 1'b0;
  stb_item_t stb_q[$];
  rsp_item_t rsp_q[$];

  always #10 clk = ~clk;

  // sub-block models: distinct pattern per core, follows sub_offs
  for (genvar i = 0; i < N; i++) begin : g_sub
    assign cif_rdata[i*DW +: DW] = {16'(16'hC1F0 + i), 4'h0, sub_offs};
    assign tmr_rdata[i*DW +: DW] = {16'(16'h7100 + i), 4'h0, sub_offs};
    assign wdg_rdata[i*DW +: DW] = {16'(16'h3D00 + i), 4'h0, sub_offs};
  end
  assign dist_rdata = {20'hD1570, sub_offs};

  mpriv_decoder #(.NCORES(N), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .core_id(core_id), .rdata(rdata), .ready(ready), .err(err),
    .cif_stb(cif_stb), .tmr_stb(tmr_stb), .wdg_stb(wdg_stb),
    .dist_stb(dist_stb), .sub_we(sub_we), .sub_offs(sub_offs),
    .sub_wdata(sub_wdata), .cif_rdata(cif_rdata), .tmr_rdata(tmr_rdata),
    .wdg_rdata(wdg_rdata), .dist_rdata(dist_rdata)
  );

  task automatic check(input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: called at a falling edge, returns at the next falling edge
  task automatic acc(input logic [12:0] a, input logic w,
                     input logic [DW-1:0] d, input logic [1:0] cid);
    stb_item_t s;
    rsp_item_t r;
    int slot;
    int idx;
    slot = int'(a[11:8]);
    s.stb = '0; s.offs = '0; s.we = w; s.wd = d; s.tag = "R11";
    r.rd = '0; r.er = 1'b0; r.tag = "R11";
    if (a[12]) begin
      s.stb[3*N] = 1'b1; s.offs = a[11:0]; s.tag = "R9";
      r.rd = {20'hD1570, a[11:0]}; r.tag = "R9";
    end else if (slot == 0) begin
      r.tag = (a[7:0] == 8'h04) ? "R3" : (a[7:0] == 8'h00) ? "R2" : "R4";
      s.tag = r.tag;
      if (a[7:0] == 8'h00) r.rd = {31'd0, ctrl_m};
      else if (a[7:0] == 8'h04) r.rd = 32'h0000_00F3;
      if (w && a[7:0] == 8'h00) ctrl_m = d[0];
    end else if (slot == 1 || (slot >= 2 && slot < 2 + N)) begin
      idx = (slot == 1) ? int'(cid) : slot - 2;
      s.tag = (slot == 1) ? "R5" : "R6"; r.tag = s.tag;
      s.stb[idx] = 1'b1; s.offs = {4'h0, a[7:0]};
      r.rd = {16'(16'hC1F0 + idx), 4'h0, 4'h0, a[7:0]};
    end else if ((slot == 6 || (slot >= 7 && slot < 7 + N)) && a[7:6] == 2'b00) begin
      idx = (slot == 6) ? int'(cid) : slot - 7;
      s.offs = {7'h00, a[4:0]};
      if (a[5]) begin
        s.stb[2*N + idx] = 1'b1; s.tag = "R8";
        r.rd = {16'(16'h3D00 + idx), 4'h0, 7'h00, a[4:0]};
      end else begin
        s.stb[N + idx] = 1'b1; s.tag = "R7";
        r.rd = {16'(16'h7100 + idx), 4'h0, 7'h00, a[4:0]};
      end
      r.tag = s.tag;
    end else begin
      r.er = 1'b1;
    end
    if (w) begin
      r.rd = '0;
      r.tag = {r.tag, "/R12"};
    end
    stb_q.push_back(s);
    rsp_q.push_back(r);
    req = 1'b1; we = w; addr = a; wdata = d; core_id = cid;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // monitor / scoreboard
  initial begin
    logic r0;
    stb_item_t s;
    rsp_item_t r;
    logic rdy_prev;
    rdy_prev = 1'b0;
    forever begin
      @(posedge clk);
      r0 = req && !rst;
      @(negedge clk);
      if (rst) begin
        rdy_prev = 1'b0;
        continue;
      end
      if (r0) begin
        s = stb_q.pop_front();
        check({s.tag, "/R10 strobes"}, 64'({dist_stb, wdg_stb, tmr_stb, cif_stb}),
              64'(s.stb));
        if (s.stb != '0) begin
          check({s.tag, " sub_offs"}, 64'(sub_offs), 64'(s.offs));
          check("R10 sub_we", 64'(sub_we), 64'(s.we));
          if (s.we) check("R10 sub_wdata", 64'(sub_wdata), 64'(s.wd));
        end
      end else if ({dist_stb, wdg_stb, tmr_stb, cif_stb} != '0) begin
        check("R10 idle strobe", 64'({dist_stb, wdg_stb, tmr_stb, cif_stb}), 64'd0);
      end
      if (ready) begin
        if (rsp_q.size() == 0) begin
          check("R1 stray ready", 64'(ready), 64'd0);
        end else begin
          r = rsp_q.pop_front();
          check({r.tag, " rdata"}, 64'(rdata), 64'(r.rd));
          check("R11 err", 64'(err), 64'(r.er));
        end
      end else if (err) begin
        check("R11 err without ready", 64'(err), 64'd0);
      end
      rdy_prev = ready;
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // reset state
    check("R1 reset ready", 64'(ready), 64'd0);
    check("R11 reset err", 64'(err), 64'd0);
    check("R10 reset strobes", 64'({dist_stb, wdg_stb, tmr_stb, cif_stb}), 64'd0);
    rst = 1'b0;
    idle(1);

    // snoop-control registers (R2, R3, R4)
    acc(13'h000, 0, 0, 0);
    acc(13'h004, 0, 0, 0);
    acc(13'h008, 0, 0, 0);
    acc(13'h00C, 0, 0, 0);
    acc(13'h000, 1, 32'hFFFF_FFFF, 0);
    acc(13'h000, 0, 0, 0);
    acc(13'h00C, 1, 32'h0000_0000, 0);
    acc(13'h000, 0, 0, 0);
    acc(13'h010, 1, 32'h0000_0000, 0);
    acc(13'h010, 0, 0, 0);
    acc(13'h000, 0, 0, 0);
    acc(13'h000, 1, 32'h0000_0002, 0);
    acc(13'h000, 0, 0, 0);
    idle(3);

    // alias and per-core interface slots (R5, R6)
    for (int c = 0; c < N; c++) acc(13'h100 | 13'(c * 4), 0, 0, 2'(c));
    for (int i = 0; i < N; i++) acc(13'(13'h200 + i * 13'h100 + 13'h44), 0, 0, 0);
    acc(13'h3F0, 1, 32'hCAFE_0001, 2);
    idle(2);

    // timers and watchdogs (R7, R8), slot edges and holes (R11)
    for (int c = 0; c < N; c++) begin
      acc(13'h600, 0, 0, 2'(c));
      acc(13'h63C, 0, 0, 2'(c));
    end
    for (int i = 0; i < N; i++) begin
      acc(13'(13'h71F + i * 13'h100), 0, 0, 0);
      acc(13'(13'h720 + i * 13'h100), 0, 0, 0);
    end
    acc(13'h824, 1, 32'h1234_5678, 0);
    acc(13'h640, 0, 0, 1);
    acc(13'h7FF, 0, 0, 1);
    idle(2);

    // distributor (R9)
    acc(13'h1000, 0, 0, 0);
    acc(13'h1FFC, 0, 0, 3);
    acc(13'h1ABC, 1, 32'hDEAD_BEEF, 0);

    // unmapped (R11)
    acc(13'hB00, 0, 0, 0);
    acc(13'hF80, 1, 32'h5555_5555, 0);
    acc(13'hC04, 0, 0, 3);
    idle(2);

    // back-to-back mixed burst (R1)
    acc(13'h000, 1, 1, 0);
    acc(13'h000, 0, 0, 0);
    acc(13'h1010, 0, 0, 0);
    acc(13'h500, 0, 0, 0);
    acc(13'h6A0, 0, 0, 0);
    acc(13'hA20, 0, 0, 0);
    acc(13'hB10, 0, 0, 0);
    acc(13'h004, 0, 0, 0);

    idle(1);
    for (int k = 0; k < 20 && (rsp_q.size() != 0 || stb_q.size() != 0); k++) idle(1);
    check("R1 all completions seen", 64'(rsp_q.size()), 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule